// File: doc/BRIEF.md
# Clocked Multi-Queue Byte Port

This block lets an external master reach four independent byte queues inside a device over one shared, clock-synchronous strobe interface. The master uses a two-bit select to pick the queue. Chip select and a strobe then start a transfer on a rising clock edge. A read strobe only moves the selected queue's read pointer. The byte shown on the bus is the prefetched head of the queue, and it is driven only while output enable is high. A write strobe stores the input byte at the tail of the selected queue.

A packet-end input seals all bytes that are still open in the selected queue. Each queue reports how many sealed bytes it still holds. Reads take the oldest bytes, so they use up sealed bytes before open ones. Each queue runs a small state machine with three states:

- LANE_EMPTY: the queue holds nothing.
- LANE_OPEN: at least one byte has not been sealed.
- LANE_SEALED: the queue holds bytes and every one of them is sealed.

The transitions are:

- EMPTY goes to OPEN on a write, or straight to SEALED on a write that comes with packet-end.
- OPEN goes to SEALED on packet-end.
- SEALED goes back to OPEN on a write without packet-end.
- OPEN or SEALED goes to EMPTY when the last byte is read.

Each queue has an empty flag and a full flag. These are registered views of the queue's state, one clock behind the occupancy.

Top module: `slave_fifo_port`

## Requirements
- R1: After reset, every queue reports empty=1, full=0 and a sealed count of 0, and data_oe is 0.
- R2: Reads, writes and packet-end act only when cs is 1 at the rising edge. With cs at 0, strobes change no queue.
- R3: data_oe equals oe, and data_out is 0 while oe is 0. oe never moves a pointer, so the same head byte stays on the bus for as long as no read is qualified.
- R4: While oe is 1 and the selected queue is not empty, data_out shows the oldest byte of that queue before any read strobe is given.
- R5: Each qualified read edge removes the head. With rd_stb and oe held at 1, bytes N, N+1, N+2 appear on consecutive clocks.
- R6: A qualified write stores data_in at the tail of the queue chosen by fifo_sel (value i selects queue i, 0 to 3). Other queues are not affected.
- R7: A read on an empty queue, or a write on a full queue (16 bytes), is ignored. A read and a write in the same edge on the same non-empty, non-full queue both take effect.
- R8: empty[i] and full[i] reflect the occupancy that queue i had before the most recent rising edge. A change at edge E shows on the flags after edge E+1.
- R9: A qualified packet-end on queue i adds all of its open bytes to its sealed count. This includes a byte written in the same edge. Reads lower the sealed count first while it is non-zero. commit_cnt[5*i +: 5] holds queue i's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_sel | input | 2 | Queue select |
| cs | input | 1 | Chip select, active high |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| oe | input | 1 | Bus output enable, active high |
| pkt_end | input | 1 | Seal open bytes of the selected queue |
| data_in | input | 8 | Byte written by the master |
| data_out | output | 8 | Head byte of selected queue when driven |
| data_oe | output | 1 | Bus drive enable |
| empty | output | 4 | Per-queue empty flags |
| full | output | 4 | Per-queue full flags |
| commit_cnt | output | 20 | Per-queue sealed byte counts, 5 bits each |

## Verification
The bench holds oe high with no read strobe to catch a design that lets output enable advance the pointer. Such a design would show a new byte where the old one should repeat. It fills one queue past 16 bytes and drains it. A design without the full guard would overwrite the head and return the wrong first byte. A design without the empty guard would wrap the pointers and report bytes that were never written. The bench also seals a packet on the same edge as a write, and reads sealed and open bytes in mixed order. A wrong commit path would show a sealed count that is off by one. Finally, the bench checks the flags exactly one clock late, so a flag that is combinational, or one that is two clocks late, fails.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
    typedef enum logic [1:0] {
        LANE_EMPTY  = 2'd0,
        LANE_OPEN   = 2'd1,
        LANE_SEALED = 2'd2
    } lane_state_t;
endpackage

// File: rtl/sfp_strobe_qual.sv
module sfp_strobe_qual #(
    parameter int NUM_FIFO = 4,
    localparam int SW = $clog2(NUM_FIFO)
) (
    input  logic [SW-1:0]       fifo_sel,
    input  logic                cs,
    input  logic                rd_stb,
    input  logic                wr_stb,
    input  logic                pkt_end,
    output logic [NUM_FIFO-1:0] rd_go,
    output logic [NUM_FIFO-1:0] wr_go,
    output logic [NUM_FIFO-1:0] pe_go
);
    for (genvar i = 0; i < NUM_FIFO; i++) begin : g_dec
        logic hit;
        assign hit      = cs && (fifo_sel == SW'(i));
        assign rd_go[i] = hit && rd_stb;
        assign wr_go[i] = hit && wr_stb;
        assign pe_go[i] = hit && pkt_end;
    end
endmodule

// File: rtl/sfp_lane.sv
module sfp_lane
    import sfp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_go,
    input  logic          wr_go,
    input  logic          pe_go,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head,
    output logic [CW-1:0] sealed_cnt,
    output logic          empty_q,
    output logic          full_q
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt, comm, pend;
    logic [CW-1:0] cnt_nxt, comm_nxt, pend_nxt, pend_mid;
    lane_state_t   state, state_nxt;
    logic          do_rd, do_wr, rd_comm, rd_pend;

    // Qualified work, guarded by occupancy before the edge
    assign do_rd   = rd_go && (state != LANE_EMPTY);
    assign do_wr   = wr_go && (cnt != CW'(DEPTH));
    assign rd_comm = do_rd && (comm != '0);
    assign rd_pend = do_rd && (comm == '0);

    always_comb begin
        cnt_nxt  = cnt + CW'(do_wr) - CW'(do_rd);
        pend_mid = pend + CW'(do_wr) - CW'(rd_pend);
        if (pe_go) begin
            comm_nxt = comm - CW'(rd_comm) + pend_mid;
            pend_nxt = '0;
        end else begin
            comm_nxt = comm - CW'(rd_comm);
            pend_nxt = pend_mid;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            LANE_EMPTY: begin
                if (do_wr) state_nxt = pe_go ? LANE_SEALED : LANE_OPEN;
            end
            LANE_OPEN: begin
                if (cnt_nxt == '0)   state_nxt = LANE_EMPTY;
                else if (pe_go)      state_nxt = LANE_SEALED;
            end
            LANE_SEALED: begin
                if (cnt_nxt == '0)        state_nxt = LANE_EMPTY;
                else if (do_wr && !pe_go) state_nxt = LANE_OPEN;
            end
            default: state_nxt = LANE_EMPTY;
        endcase
    end

    // State register with counters and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= LANE_EMPTY;
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            comm   <= '0;
            pend   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            comm  <= comm_nxt;
            pend  <= pend_nxt;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= din;
    end

    // Output process: flags lag occupancy by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            full_q  <= 1'b0;
        end else begin
            empty_q <= (state == LANE_EMPTY);
            full_q  <= (cnt == CW'(DEPTH));
        end
    end

    assign head       = mem[rd_ptr];
    assign sealed_cnt = comm;
endmodule

// File: rtl/sfp_bus_drive.sv
module sfp_bus_drive #(
    parameter int NUM_FIFO = 4,
    parameter int DW       = 8,
    localparam int SW = $clog2(NUM_FIFO)
) (
    input  logic [NUM_FIFO*DW-1:0] heads,
    input  logic [SW-1:0]          fifo_sel,
    input  logic                   oe,
    output logic [DW-1:0]          data_out,
    output logic                   data_oe
);
    assign data_out = oe ? heads[fifo_sel*DW +: DW] : '0;
    assign data_oe  = oe;
endmodule

// File: rtl/slave_fifo_port.sv
module slave_fifo_port #(
    parameter int NUM_FIFO = 4,
    parameter int DEPTH    = 16,
    parameter int DW       = 8,
    localparam int SW = $clog2(NUM_FIFO),
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SW-1:0]          fifo_sel,
    input  logic                   cs,
    input  logic                   rd_stb,
    input  logic                   wr_stb,
    input  logic                   oe,
    input  logic                   pkt_end,
    input  logic [DW-1:0]          data_in,
    output logic [DW-1:0]          data_out,
    output logic                   data_oe,
    output logic [NUM_FIFO-1:0]    empty,
    output logic [NUM_FIFO-1:0]    full,
    output logic [NUM_FIFO*CW-1:0] commit_cnt
);
    logic [NUM_FIFO-1:0]    rd_go, wr_go, pe_go;
    logic [NUM_FIFO*DW-1:0] heads;

    sfp_strobe_qual #(.NUM_FIFO(NUM_FIFO)) u_qual (
        .fifo_sel(fifo_sel), .cs(cs), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .pkt_end(pkt_end), .rd_go(rd_go), .wr_go(wr_go), .pe_go(pe_go)
    );

    for (genvar i = 0; i < NUM_FIFO; i++) begin : g_lane
        sfp_lane #(.DEPTH(DEPTH), .DW(DW)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .rd_go(rd_go[i]), .wr_go(wr_go[i]), .pe_go(pe_go[i]),
            .din(data_in),
            .head(heads[i*DW +: DW]),
            .sealed_cnt(commit_cnt[i*CW +: CW]),
            .empty_q(empty[i]), .full_q(full[i])
        );
    end

    sfp_bus_drive #(.NUM_FIFO(NUM_FIFO), .DW(DW)) u_bus (
        .heads(heads), .fifo_sel(fifo_sel), .oe(oe),
        .data_out(data_out), .data_oe(data_oe)
    );
endmodule

// File: rtl/slave_fifo_port_chk.sv
module slave_fifo_port_chk #(
    parameter int NUM_FIFO = 4,
    parameter int DEPTH    = 16,
    parameter int DW       = 8,
    localparam int SW = $clog2(NUM_FIFO),
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [SW-1:0]          fifo_sel,
    input logic                   cs,
    input logic                   wr_stb,
    input logic                   oe,
    input logic [DW-1:0]          data_out,
    input logic                   data_oe,
    input logic [NUM_FIFO-1:0]    empty,
    input logic [NUM_FIFO-1:0]    full,
    input logic [NUM_FIFO*CW-1:0] commit_cnt
);
    // R3: undriven bus is quiet
    a_r3_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (!data_oe && data_out == '0));

    // R2: without chip select no sealed count moves
    a_r2_idle_commit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> $stable(commit_cnt));

    for (genvar k = 0; k < NUM_FIFO; k++) begin : g_k
        // R7: a queue is never both empty and full
        a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(empty[k] && full[k]));

        // R8: a write makes the empty flag drop one clock after the change
        a_r8_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
            (cs && wr_stb && fifo_sel == SW'(k)) |-> ##2 !empty[k]);

        // R9: sealed count never exceeds the depth
        a_r9_commit_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            commit_cnt[k*CW +: CW] <= CW'(DEPTH));
    end
endmodule

bind slave_fifo_port slave_fifo_port_chk #(
    .NUM_FIFO(NUM_FIFO), .DEPTH(DEPTH), .DW(DW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_sel(fifo_sel), .cs(cs), .wr_stb(wr_stb),
    .oe(oe), .data_out(data_out), .data_oe(data_oe), .empty(empty),
    .full(full), .commit_cnt(commit_cnt)
);

// File: tb/slave_fifo_port_tb.sv
`timescale 1ns/1ps
module slave_fifo_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fifo_sel = '0;
    logic        cs = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, oe = 1'b0, pkt_end = 1'b0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic [3:0]  empty, full;
    logic [19:0] commit_cnt;

    int checks = 0;
    int errors = 0;

    byte unsigned q[4][$];
    int  comm[4];
    int  pend[4];
    bit  e_empty[4];
    bit  e_full[4];

    always #2.5 clk = ~clk;

    slave_fifo_port u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_sel(fifo_sel), .cs(cs), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .oe(oe), .pkt_end(pkt_end), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .empty(empty), .full(full),
        .commit_cnt(commit_cnt)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < 4; i++) begin
            chk(req, "R8 empty", int'(empty[i]), int'(e_empty[i]));
            chk(req, "R8 full", int'(full[i]), int'(e_full[i]));
            chk(req, "R9 sealed", int'(commit_cnt[i*5 +: 5]), comm[i]);
        end
    endtask

    // One clock: drive at negedge, check bus, update model at posedge, check registers
    task automatic step(input string req, input logic [1:0] s, input logic c,
                        input logic r, input logic w, input logic o,
                        input logic p, input logic [7:0] d);
        @(negedge clk);
        fifo_sel = s; cs = c; rd_stb = r; wr_stb = w; oe = o; pkt_end = p; data_in = d;
        #1;
        chk(req, "R3 data_oe", int'(data_oe), int'(o));
        if (!o) chk(req, "R3 quiet bus", int'(data_out), 0);
        else if (q[s].size() > 0) chk(req, "R4/R5 head", int'(data_out), int'(q[s][0]));
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            e_empty[i] = (q[i].size() == 0);
            e_full[i]  = (q[i].size() == 16);
        end
        if (c) begin
            int  pre;
            bit  dr, dw;
            pre = q[s].size();
            dr = r && pre > 0;
            dw = w && pre < 16;
            if (dr) begin
                void'(q[s].pop_front());
                if (comm[s] > 0) comm[s]--; else pend[s]--;
            end
            if (dw) begin
                q[s].push_back(d);
                pend[s]++;
            end
            if (p) begin
                comm[s] += pend[s];
                pend[s] = 0;
            end
        end
        #1;
        check_regs(req);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            e_empty[i] = 1; e_full[i] = 0; comm[i] = 0; pend[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check_regs("R1");
        chk("R1", "data_oe", int'(data_oe), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: writes into queue 0 with bus quiet (R3)
        step("R6", 2'd0, 1, 0, 1, 0, 0, 8'h11);
        step("R6", 2'd0, 1, 0, 1, 0, 0, 8'h22);
        step("R6", 2'd0, 1, 0, 1, 0, 0, 8'h33);
        // R4: prefetched head, oe alone holds it (R3)
        step("R4", 2'd0, 1, 0, 0, 1, 0, 8'h00);
        step("R3", 2'd0, 1, 0, 0, 1, 0, 8'h00);
        chk("R3", "head held", int'(data_out), 8'h11);
        // R5: burst read
        step("R5", 2'd0, 1, 1, 0, 1, 0, 8'h00);
        step("R5", 2'd0, 1, 1, 0, 1, 0, 8'h00);
        step("R5", 2'd0, 1, 0, 0, 1, 0, 8'h00);
        chk("R5", "burst third", int'(data_out), 8'h33);

        // R2: no chip select, strobes ignored
        step("R2", 2'd1, 0, 0, 1, 0, 1, 8'hAA);
        step("R2", 2'd1, 0, 0, 0, 1, 0, 8'h00);
        chk("R2", "queue 1 empty", int'(empty[1]), 1);

        // R6: distinct queues, R9 seal on same edge as write
        step("R6", 2'd1, 1, 0, 1, 0, 0, 8'h41);
        step("R6", 2'd2, 1, 0, 1, 0, 0, 8'h51);
        step("R9", 2'd2, 1, 0, 1, 0, 1, 8'h52);
        step("R9", 2'd2, 1, 0, 1, 0, 0, 8'h53);
        step("R9", 2'd2, 1, 1, 0, 1, 0, 8'h00);
        step("R9", 2'd2, 1, 1, 0, 1, 1, 8'h00);
        step("R9", 2'd2, 1, 1, 0, 1, 0, 8'h00);
        step("R6", 2'd1, 1, 0, 0, 1, 0, 8'h00);
        chk("R6", "queue 1 head", int'(data_out), 8'h41);

        // R7: read on empty queue 3
        step("R7", 2'd3, 1, 1, 0, 1, 0, 8'h00);
        step("R7", 2'd3, 1, 0, 1, 1, 0, 8'h77);
        step("R7", 2'd3, 1, 0, 0, 1, 0, 8'h00);
        chk("R7", "queue 3 head", int'(data_out), 8'h77);

        // R7/R8: fill queue 1 past full, then drain
        for (int n = 0; n < 17; n++) step("R7", 2'd1, 1, 0, 1, 0, n == 8, 8'(8'h80 + n));
        step("R8", 2'd1, 1, 0, 0, 0, 0, 8'h00);
        chk("R8", "queue 1 full", int'(full[1]), 1);
        step("R7", 2'd1, 1, 1, 1, 1, 0, 8'hEE);
        for (int n = 0; n < 17; n++) step("R5", 2'd1, 1, 1, 0, 1, 0, 8'h00);
        step("R7", 2'd1, 1, 1, 1, 1, 0, 8'hC5);
        step("R7", 2'd1, 1, 0, 0, 1, 1, 8'h00);
        step("R8", 2'd1, 1, 0, 0, 1, 0, 8'h00);
        chk("R7", "queue 1 head after mixed", int'(data_out), 8'hC5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule